// File: doc/BRIEF.md
# Preamble-Guarded Serial Format Configuration Loader

This block holds the small format register that tells an audio serial receiver how to interpret its input: how many bit clocks make up one word-clock period (or, with an externally supplied bit clock, which bit-clock edge samples the data), whether samples sit against the start or the end of each half-frame, whether the I2S one-bit delay is applied, and whether words are 16 or 18 bits. The register comes out of reset holding a usable default, so a system that is happy with that format never writes it.

To change the format, a host shifts an 8-bit code in on the shared control pin. One bit is taken at every falling edge of the word clock, first bit first, while the serial data line is held high. The code is accepted only when its first three bits match a fixed guard pattern, when it is not the one reserved error code, and when the receiver has not yet switched to an external bit clock. Pulling the data line low at any point abandons the code in progress, so the next write starts again from its first bit. The block also reports the effective bit-clock multiple, which is forced to 48 whenever the master clock runs at 384 times the sample rate.

Top module: `fmt_cfg_loader`

## Requirements
- R1: Code bits are taken one per falling word-clock edge; the first bit taken is bit 1 and the eighth bit taken is bit 8, and the eighth bit completes the code.
- R2: A code is accepted only if bits 1, 2 and 3 are 0, 1 and 0; a code with any other guard leaves every output unchanged.
- R3: The code 0,1,0,0,0,0,0,0 (bits 1 to 8) is rejected and leaves every output unchanged.
- R4: A code during which the data line goes low before the eighth falling edge is not accepted.
- R5: Bits 4 and 5 of an accepted code load `ratio_code` as {bit 4, bit 5}; `bclk_per_word` then reads 32 for 00, 64 for 10 and 128 for 11.
- R6: An accepted code whose bits 4 and 5 are 0,1 leaves `ratio_code` unchanged while its other fields still load.
- R7: `sample_on_fall` equals bit 5 of the stored code: 1 for 11 (falling-edge sampling), 0 for 10 (rising-edge sampling).
- R8: Bit 6 loads `right_just` (1 = right-justified), bit 7 loads `i2s_en`, bit 8 loads `word_16` (1 = 16-bit words).
- R9: While `ext_clk_mode` is high no code is accepted and all stored fields hold.
- R10: While `mclk_384` is high, `bclk_per_word` reads 48 one clock later, whatever `ratio_code` holds.
- R11: After reset `ratio_code` is 10, `right_just` 1, `i2s_en` 0, `word_16` 0 and `bclk_per_word` 64.
- R12: A low level on the data line restarts the bit count, so a complete code sent after it is accepted on its own eight bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| word_clk | input | 1 | Word (left/right) clock, asynchronous, synchronised inside |
| code_pin | input | 1 | Shared control pin carrying code bits |
| data_line | input | 1 | Serial data line level, must be high during a write |
| ext_clk_mode | input | 1 | High once the receiver runs from an external bit clock |
| mclk_384 | input | 1 | High when the master clock is 384 times the sample rate |
| ratio_code | output | 2 | Stored bits 4,5 (ratio or sample edge selection) |
| sample_on_fall | output | 1 | External bit clock samples on its falling edge |
| right_just | output | 1 | Right-justified data |
| i2s_en | output | 1 | I2S framing enabled |
| word_16 | output | 1 | 16-bit words (0 = 18-bit) |
| bclk_per_word | output | 8 | Effective bit clocks per word-clock period |

## Verification
A bit counter that drifts out of step, or a shift register holding stale bits, shows up at the ports only when the next code completes: the wrong bits land in the fields, or a valid code is judged by a misaligned guard and dropped, so each write is checked a few clocks after its eighth falling edge. A missing restart on a low data line is exposed by sending partial junk before a full code, and a wrongly open gate (guard, error code, external mode) shows as a field that changes when it should hold. The 384 override is visible one clock after its input moves.

// File: rtl/fcl_pkg.sv
package fcl_pkg;
  localparam int CODE_W = 8;
  localparam int PRE_W  = 3;
  localparam logic [PRE_W-1:0]  GUARD    = 3'b010;
  localparam logic [CODE_W-1:0] ERR_CODE = 8'b0100_0000;
  localparam logic [1:0]        RSV_RATIO = 2'b01;

  typedef struct packed {
    logic [1:0] ratio;
    logic       right_just;
    logic       i2s;
    logic       word16;
  } fmt_cfg_t;

  function automatic logic [7:0] ratio_mult(input logic [1:0] r, input logic m384);
    logic [7:0] v;
    if (m384) v = 8'd48;
    else begin
      case (r)
        2'b00:   v = 8'd32;
        2'b11:   v = 8'd128;
        default: v = 8'd64;
      endcase
    end
    return v;
  endfunction
endpackage

// File: rtl/fcl_sync.sv
module fcl_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         fall0
);
  logic [W-1:0] st [STAGES];
  logic         prev0;

  always_ff @(posedge clk) begin
    if (rst) st[0] <= '0;
    else     st[0] <= d;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) st[i] <= '0;
        else     st[i] <= st[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev0 <= 1'b0;
    else     prev0 <= st[STAGES-1][0];
  end

  assign q     = st[STAGES-1];
  assign fall0 = prev0 & ~st[STAGES-1][0];
endmodule

// File: rtl/fcl_shift.sv
module fcl_shift #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall,
  input  logic              bit_in,
  input  logic              hold_ok,
  output logic              code_valid,
  output logic [CODE_W-1:0] code_word
);
  localparam int CNT_W = $clog2(CODE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CODE_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0] sreg_q;
  logic              valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      sreg_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (!hold_ok) begin
        cnt_q <= '0;
      end else if (fall) begin
        sreg_q <= {sreg_q[CODE_W-2:0], bit_in};
        if (cnt_q == LAST) begin
          cnt_q   <= '0;
          valid_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign code_valid = valid_q;
  assign code_word  = sreg_q;
endmodule

// File: rtl/fcl_regs.sv
module fcl_regs
  import fcl_pkg::*;
#(
  parameter logic [1:0] DEF_RATIO = 2'b10,
  parameter logic       DEF_RJ    = 1'b1,
  parameter logic       DEF_I2S   = 1'b0,
  parameter logic       DEF_W16   = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              code_valid,
  input  logic [CODE_W-1:0] code_word,
  input  logic              ext_mode,
  input  logic              mode384,
  output fmt_cfg_t          cfg,
  output logic [7:0]        mult
);
  localparam fmt_cfg_t DEF_CFG = '{ratio: DEF_RATIO, right_just: DEF_RJ,
                                   i2s: DEF_I2S, word16: DEF_W16};

  fmt_cfg_t   cur_q, nxt;
  logic [7:0] mult_q;
  logic       accept;

  always_comb begin
    accept = code_valid
           && (code_word[CODE_W-1 -: PRE_W] == GUARD)
           && (code_word != ERR_CODE)
           && !ext_mode;
    nxt = cur_q;
    if (accept) begin
      if (code_word[4:3] != RSV_RATIO) nxt.ratio = code_word[4:3];
      nxt.right_just = code_word[2];
      nxt.i2s        = code_word[1];
      nxt.word16     = code_word[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= DEF_CFG;
      mult_q <= ratio_mult(DEF_RATIO, mode384);
    end else begin
      cur_q  <= nxt;
      mult_q <= ratio_mult(nxt.ratio, mode384);
    end
  end

  assign cfg  = cur_q;
  assign mult = mult_q;
endmodule

// File: rtl/fmt_cfg_loader.sv
module fmt_cfg_loader
  import fcl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       word_clk,
  input  logic       code_pin,
  input  logic       data_line,
  input  logic       ext_clk_mode,
  input  logic       mclk_384,
  output logic [1:0] ratio_code,
  output logic       sample_on_fall,
  output logic       right_just,
  output logic       i2s_en,
  output logic       word_16,
  output logic [7:0] bclk_per_word
);
  logic [2:0]        sync_q;
  logic              wclk_fall;
  logic              code_valid;
  logic [CODE_W-1:0] code_word;
  fmt_cfg_t          cfg;

  fcl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .d    ({data_line, code_pin, word_clk}),
    .q    (sync_q),
    .fall0(wclk_fall)
  );

  fcl_shift #(.CODE_W(CODE_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .fall      (wclk_fall),
    .bit_in    (sync_q[1]),
    .hold_ok   (sync_q[2]),
    .code_valid(code_valid),
    .code_word (code_word)
  );

  fcl_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .code_valid(code_valid),
    .code_word (code_word),
    .ext_mode  (ext_clk_mode),
    .mode384   (mclk_384),
    .cfg       (cfg),
    .mult      (bclk_per_word)
  );

  assign ratio_code     = cfg.ratio;
  assign sample_on_fall = cfg.ratio[0];
  assign right_just     = cfg.right_just;
  assign i2s_en         = cfg.i2s;
  assign word_16        = cfg.word16;
endmodule

// File: rtl/fcl_checker.sv
module fcl_checker (
  input logic       clk,
  input logic       rst,
  input logic       code_valid,
  input logic [7:0] code_word,
  input logic       ext_clk_mode,
  input logic       mclk_384,
  input logic [1:0] ratio_code,
  input logic       right_just,
  input logic       i2s_en,
  input logic       word_16,
  input logic [7:0] bclk_per_word
);
  logic [4:0] flds;
  assign flds = {ratio_code, right_just, i2s_en, word_16};

  p_guard_r2: assert property (@(posedge clk) disable iff (rst)
    (code_valid && code_word[7:5] != 3'b010) |=> $stable(flds));

  p_err_code_r3: assert property (@(posedge clk) disable iff (rst)
    (code_valid && code_word == 8'b0100_0000) |=> $stable(flds));

  p_ext_hold_r9: assert property (@(posedge clk) disable iff (rst)
    ext_clk_mode |=> $stable(flds));

  p_load_r8: assert property (@(posedge clk) disable iff (rst)
    (code_valid && code_word[7:5] == 3'b010 && code_word != 8'b0100_0000 && !ext_clk_mode)
    |=> (right_just == $past(code_word[2]) && i2s_en == $past(code_word[1])
         && word_16 == $past(code_word[0])));

  p_no_rsv_r6: assert property (@(posedge clk) disable iff (rst)
    (code_valid && code_word[4:3] == 2'b01) |=> $stable(ratio_code));

  p_force48_r10: assert property (@(posedge clk) disable iff (rst)
    $past(mclk_384) |-> bclk_per_word == 8'd48);

  p_map128_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(mclk_384) && ratio_code == 2'b11) |-> bclk_per_word == 8'd128);
endmodule

bind fmt_cfg_loader fcl_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .code_valid   (code_valid),
  .code_word    (code_word),
  .ext_clk_mode (ext_clk_mode),
  .mclk_384     (mclk_384),
  .ratio_code   (ratio_code),
  .right_just   (right_just),
  .i2s_en       (i2s_en),
  .word_16      (word_16),
  .bclk_per_word(bclk_per_word)
);

// File: tb/fmt_cfg_loader_test.sv
module fmt_cfg_loader_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic word_clk = 1'b0, code_pin = 1'b0, data_line = 1'b1;
  logic ext_clk_mode = 1'b0, mclk_384 = 1'b0;
  logic [1:0] ratio_code;
  logic sample_on_fall, right_just, i2s_en, word_16;
  logic [7:0] bclk_per_word;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fmt_cfg_loader uut (
    .clk(clk), .rst(rst), .word_clk(word_clk), .code_pin(code_pin),
    .data_line(data_line), .ext_clk_mode(ext_clk_mode), .mclk_384(mclk_384),
    .ratio_code(ratio_code), .sample_on_fall(sample_on_fall),
    .right_just(right_just), .i2s_en(i2s_en), .word_16(word_16),
    .bclk_per_word(bclk_per_word)
  );

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic check_all(input string req, input int r, input int rj,
                           input int i2, input int w, input int m);
    check({req, " ratio_code"}, ratio_code, r);
    check({req, " right_just"}, right_just, rj);
    check({req, " i2s_en"}, i2s_en, i2);
    check({req, " word_16"}, word_16, w);
    check({req, " bclk_per_word"}, bclk_per_word, m);
  endtask

  task automatic send_bit(input logic b);
    code_pin = b;
    word_clk = 1'b1;
    repeat (4) @(negedge clk);
    word_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic restart();
    data_line = 1'b0;
    repeat (6) @(negedge clk);
    data_line = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // b is written bit 1 first (MSB of the literal = bit 1)
  task automatic send_code(input logic [7:0] b);
    restart();
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    check_all("R11", 2, 1, 0, 0, 64);
  endtask

  task automatic t_load();
    send_code(8'b010_11_0_1_1);
    check_all("R1 R5 R8", 3, 0, 1, 1, 128);
    send_code(8'b010_00_1_0_0);
    check_all("R5 R8", 0, 1, 0, 0, 32);
  endtask

  task automatic t_guard();
    send_code(8'b110_10_0_1_1);
    check_all("R2", 0, 1, 0, 0, 32);
    send_code(8'b011_11_0_1_1);
    check_all("R2", 0, 1, 0, 0, 32);
  endtask

  task automatic t_err();
    send_code(8'b0100_0000);
    check_all("R3", 0, 1, 0, 0, 32);
  endtask

  task automatic t_reserved();
    send_code(8'b010_01_0_1_1);
    check_all("R6", 0, 0, 1, 1, 32);
  endtask

  task automatic t_hold_low();
    logic [7:0] c = 8'b010_11_1_0_0;
    restart();
    for (int i = 7; i >= 3; i--) send_bit(c[i]);
    data_line = 1'b0;
    repeat (6) @(negedge clk);
    data_line = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 2; i >= 0; i--) send_bit(c[i]);
    repeat (6) @(negedge clk);
    check_all("R4", 0, 0, 1, 1, 32);
  endtask

  task automatic t_restart();
    data_line = 1'b0;
    repeat (6) @(negedge clk);
    data_line = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    send_code(8'b010_10_1_0_0);
    check_all("R12", 2, 1, 0, 0, 64);
  endtask

  task automatic t_384();
    mclk_384 = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R10 bclk_per_word", bclk_per_word, 48);
    send_code(8'b010_11_0_0_0);
    check("R10 after 128 code", bclk_per_word, 48);
    mclk_384 = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R10 release", bclk_per_word, 128);
  endtask

  task automatic t_ext();
    send_code(8'b010_11_0_0_0);
    ext_clk_mode = 1'b1;
    @(negedge clk);
    check("R7 falling edge", sample_on_fall, 1);
    ext_clk_mode = 1'b0;
    send_code(8'b010_10_0_0_0);
    ext_clk_mode = 1'b1;
    @(negedge clk);
    check("R7 rising edge", sample_on_fall, 0);
    send_code(8'b010_11_1_1_1);
    check_all("R9", 2, 0, 0, 0, 64);
    check("R9 sample_on_fall", sample_on_fall, 0);
    ext_clk_mode = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_load();
    t_guard();
    t_err();
    t_reserved();
    t_hold_low();
    t_restart();
    t_384();
    t_ext();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule